// File: doc/BRIEF.md
# Timer slave-mode trigger controller

This block is the counting core of a general-purpose timer, with a slave controller in front of it. One of eight trigger sources is routed to a common trigger line. The sources are four internal triggers from neighbouring timers, two filtered timer inputs, a filtered external trigger, and a detector that pulses on every transition of timer input 1.

A 3-bit mode field decides what the counter does with that trigger line or with the two timer inputs. The counter can run freely on the internal clock, or decode a quadrature encoder on one or both inputs. It can be cleared by a trigger edge, gated by the trigger level, started by a trigger edge, or clocked by trigger edges.

The counter wraps between zero and a reload value and pulses an update output on every wrap and every trigger reinitialisation. All inputs arrive already synchronous and filtered. Every edge is found by comparing a registered sample with the sample before it. A change on an input that is sampled at one clock edge therefore takes effect at the next clock edge. The block is intended to be instantiated beside a register file that supplies the mode, the selection, the enable and the reload value.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count_o` is 0, `count_down_o` is 0 and `update_o` is 0. A trigger source that is already high when reset is released produces no edge.
- R2: In mode 000 the counter advances by one on every clock while `cnt_en_i` is 1, and holds while it is 0.
- R3: Counting up from `reload_i`, the counter goes to 0. Counting down from 0, it goes to `reload_i`. Each wrap raises `update_o` for exactly one cycle, together with the new count.
- R4: In mode 111, with `cnt_en_i` at 1, each rising edge of the trigger line advances the counter by one. An input change sampled at one clock edge changes the count at the following edge. With `cnt_en_i` at 0, edges are ignored.
- R5: In mode 101 the counter advances once per cycle in which the sampled trigger is high. It keeps its value, without clearing, while the trigger is low.
- R6: Mode 101 combined with trigger select 100 (the transition detector) never counts.
- R7: In mode 110 the counter holds at its value until a rising trigger edge. That edge advances it, and it then advances every cycle after the trigger falls. `cnt_en_i` is ignored in this mode.
- R8: In mode 100 the counter runs on the internal clock while `cnt_en_i` is 1. A rising trigger edge loads 0 and raises `update_o`, whatever the value of `cnt_en_i`.
- R9: In mode 001 only edges of input 2 count. A rise steps up when input 1 is high and down when it is low. A fall does the reverse. Edges of input 1 are ignored.
- R10: In mode 010 only edges of input 1 count. A rise steps up when input 2 is low and down when it is high. A fall does the reverse. Edges of input 2 are ignored.
- R11: In mode 011 an edge of either input counts, using the rules of R9 and R10. A cycle in which both inputs have edges makes no step. `count_down_o` is 1 after a down step and 0 after an up step, and it is 0 in every non-encoder mode.
- R12: Changing `trig_sel_i` to a source that is already high produces no trigger edge.
- R13: Trigger select codes 000 to 011 pick `int_trig_i` bits 0 to 3. Code 100 picks the transition detector on input 1, 101 picks input 1, 110 picks input 2, and 111 picks `ext_trig_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Counter enable |
| trig_sel_i | input | 3 | Trigger source select |
| slave_mode_i | input | 3 | Slave mode select |
| int_trig_i | input | 4 | Internal trigger inputs 0 to 3 |
| in1_i | input | 1 | Filtered timer input 1 |
| in2_i | input | 1 | Filtered timer input 2 |
| ext_trig_i | input | 1 | Filtered external trigger |
| reload_i | input | 16 | Auto-reload value |
| count_o | output | 16 | Counter value |
| count_down_o | output | 1 | Direction of the last encoder step, 1 = down |
| update_o | output | 1 | One-cycle update event |

## Verification
The hardest situations to reach are the ones where an edge must not appear. One is a change of trigger selection onto a source that is already high. The other is a quadrature cycle in which both inputs flip at the same time. To reach the first, the bench holds an internal trigger high while it is deselected, switches the selection to it in an edge-counting mode, and then checks that the count is unchanged. To reach the second, the bench drives both encoder inputs at the same falling clock edge after a legal sequence has been walked through. It then proves the counter is still live with a real pulse, or with a later legal step.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

  localparam int N_INT_TRIG = 4;

  typedef enum logic [2:0] {
    MD_OFF    = 3'b000,
    MD_ENC_B  = 3'b001,
    MD_ENC_A  = 3'b010,
    MD_ENC_AB = 3'b011,
    MD_RESET  = 3'b100,
    MD_GATE   = 3'b101,
    MD_TRIG   = 3'b110,
    MD_EXTCLK = 3'b111
  } slave_mode_e;

  typedef enum logic [2:0] {
    TS_INT0   = 3'b000,
    TS_INT1   = 3'b001,
    TS_INT2   = 3'b010,
    TS_INT3   = 3'b011,
    TS_A_ANY  = 3'b100,
    TS_A      = 3'b101,
    TS_B      = 3'b110,
    TS_EXT    = 3'b111
  } trig_sel_e;

endpackage

// File: rtl/tmr_trig_front.sv
module tmr_trig_front
  import tmr_slave_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            sel,
  input  logic [N_INT_TRIG-1:0] itr,
  input  logic                  in_a,
  input  logic                  in_b,
  input  logic                  ext,
  output logic                  a_lvl,
  output logic                  b_lvl,
  output logic                  a_rise,
  output logic                  a_fall,
  output logic                  b_rise,
  output logic                  b_fall,
  output logic                  trg_lvl,
  output logic                  trg_rise
);

  logic [2:0] sel_q;
  logic       armed_q;
  logic       a_q, a_p, b_q, b_p;
  logic       trg_q, trg_p;
  logic       trg_raw;
  logic       reprime;

  // a new selection or a fresh reset loads both samples alike, so no edge
  assign reprime = !armed_q || (sel != sel_q);

  always_comb begin
    case (sel)
      TS_A_ANY: trg_raw = in_a ^ a_q;
      TS_A:     trg_raw = in_a;
      TS_B:     trg_raw = in_b;
      TS_EXT:   trg_raw = ext;
      default:  trg_raw = itr[sel[1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 3'b000;
      armed_q <= 1'b0;
      a_q     <= 1'b0;
      a_p     <= 1'b0;
      b_q     <= 1'b0;
      b_p     <= 1'b0;
      trg_q   <= 1'b0;
      trg_p   <= 1'b0;
    end else begin
      sel_q   <= sel;
      armed_q <= 1'b1;
      if (!armed_q) begin
        a_q <= in_a;
        a_p <= in_a;
        b_q <= in_b;
        b_p <= in_b;
      end else begin
        a_p <= a_q;
        a_q <= in_a;
        b_p <= b_q;
        b_q <= in_b;
      end
      if (reprime) begin
        trg_q <= trg_raw;
        trg_p <= trg_raw;
      end else begin
        trg_p <= trg_q;
        trg_q <= trg_raw;
      end
    end
  end

  assign a_lvl    = a_q;
  assign b_lvl    = b_q;
  assign a_rise   = a_q & ~a_p;
  assign a_fall   = ~a_q & a_p;
  assign b_rise   = b_q & ~b_p;
  assign b_fall   = ~b_q & b_p;
  assign trg_lvl  = trg_q;
  assign trg_rise = trg_q & ~trg_p;

  // R12: the cycle after a re-prime shows no trigger edge
  a_r12_reprime_quiet: assert property (@(posedge clk) disable iff (rst)
    reprime |=> !trg_rise);

  // R1: the first cycle after reset carries no encoder edge
  a_r1_no_start_edge: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !(a_rise || a_fall || b_rise || b_fall));

endmodule

// File: rtl/tmr_mode_ctl.sv
module tmr_mode_ctl
  import tmr_slave_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic [2:0] sel,
  input  logic       cen,
  input  logic       a_lvl,
  input  logic       b_lvl,
  input  logic       a_rise,
  input  logic       a_fall,
  input  logic       b_rise,
  input  logic       b_fall,
  input  logic       trg_lvl,
  input  logic       trg_rise,
  output logic       step,
  output logic       down,
  output logic       reinit,
  output logic       enc
);

  logic run_q;
  logic a_edge, b_edge;
  logic a_down, b_down;

  assign a_edge = a_rise | a_fall;
  assign b_edge = b_rise | b_fall;
  // input-1 edge: up when it rises with input 2 low or falls with it high
  assign a_down = a_rise ? b_lvl : ~b_lvl;
  // input-2 edge: up when it rises with input 1 high or falls with it low
  assign b_down = b_rise ? ~a_lvl : a_lvl;

  always_comb begin
    step   = 1'b0;
    down   = 1'b0;
    reinit = 1'b0;
    enc    = 1'b0;
    case (mode)
      MD_OFF:    step = cen;
      MD_ENC_B: begin
        enc  = 1'b1;
        step = cen & b_edge;
        down = b_down;
      end
      MD_ENC_A: begin
        enc  = 1'b1;
        step = cen & a_edge;
        down = a_down;
      end
      MD_ENC_AB: begin
        enc  = 1'b1;
        step = cen & (a_edge ^ b_edge);
        down = a_edge ? a_down : b_down;
      end
      MD_RESET: begin
        step   = cen;
        reinit = trg_rise;
      end
      MD_GATE:   step = cen & trg_lvl & (sel != TS_A_ANY);
      MD_TRIG:   step = run_q | trg_rise;
      MD_EXTCLK: step = cen & trg_rise;
      default:   step = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= (mode == MD_TRIG) && (run_q || trg_rise);
  end

  // R6: gating on the transition detector never produces a step
  a_r6_gate_detector_blocked: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_GATE && sel == TS_A_ANY) |-> !step);

  // R11: simultaneous edges on both inputs are not counted
  a_r11_both_edges_dropped: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_ENC_AB && a_edge && b_edge) |-> !step);

  // R7: once started in trigger mode, counting continues
  a_r7_keeps_running: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_TRIG && trg_rise) |=> (mode != MD_TRIG || step));

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] arr,
  input  logic             step,
  input  logic             down,
  input  logic             reinit,
  input  logic             enc,
  output logic [CNT_W-1:0] cnt,
  output logic             dir,
  output logic             upd
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic             upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
      dir_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (!enc) dir_q <= 1'b0;
      if (reinit) begin
        cnt_q <= ZERO;
        upd_q <= 1'b1;
      end else if (step) begin
        if (enc) dir_q <= down;
        if (down) begin
          if (cnt_q == ZERO) begin
            cnt_q <= arr;
            upd_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end else begin
          if (cnt_q >= arr) begin
            cnt_q <= ZERO;
            upd_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
      end
    end
  end

  assign cnt = cnt_q;
  assign dir = dir_q;
  assign upd = upd_q;

  // R2: without a step or reinit the count does not move
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!step && !reinit) |=> $stable(cnt_q));

  // R3: an up step below the reload value adds exactly one
  a_r3_up_increment: assert property (@(posedge clk) disable iff (rst)
    (step && !down && !reinit && cnt_q < arr) |=> (cnt_q == $past(cnt_q) + ONE));

  // R3: update pulses only land on zero or the reload value
  a_r3_update_value: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> (cnt_q == ZERO || cnt_q == $past(arr)));

  // R8: a reinit request clears the count and raises update
  a_r8_reinit_clears: assert property (@(posedge clk) disable iff (rst)
    reinit |=> (cnt_q == ZERO && upd_q));

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tmr_slave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cnt_en_i,
  input  logic [2:0]            trig_sel_i,
  input  logic [2:0]            slave_mode_i,
  input  logic [N_INT_TRIG-1:0] int_trig_i,
  input  logic                  in1_i,
  input  logic                  in2_i,
  input  logic                  ext_trig_i,
  input  logic [CNT_W-1:0]      reload_i,
  output logic [CNT_W-1:0]      count_o,
  output logic                  count_down_o,
  output logic                  update_o
);

  logic a_lvl, b_lvl, a_rise, a_fall, b_rise, b_fall;
  logic trg_lvl, trg_rise;
  logic step, down, reinit, enc;

  tmr_trig_front u_front (
    .clk      (clk),
    .rst      (rst),
    .sel      (trig_sel_i),
    .itr      (int_trig_i),
    .in_a     (in1_i),
    .in_b     (in2_i),
    .ext      (ext_trig_i),
    .a_lvl    (a_lvl),
    .b_lvl    (b_lvl),
    .a_rise   (a_rise),
    .a_fall   (a_fall),
    .b_rise   (b_rise),
    .b_fall   (b_fall),
    .trg_lvl  (trg_lvl),
    .trg_rise (trg_rise)
  );

  tmr_mode_ctl u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode     (slave_mode_i),
    .sel      (trig_sel_i),
    .cen      (cnt_en_i),
    .a_lvl    (a_lvl),
    .b_lvl    (b_lvl),
    .a_rise   (a_rise),
    .a_fall   (a_fall),
    .b_rise   (b_rise),
    .b_fall   (b_fall),
    .trg_lvl  (trg_lvl),
    .trg_rise (trg_rise),
    .step     (step),
    .down     (down),
    .reinit   (reinit),
    .enc      (enc)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .arr    (reload_i),
    .step   (step),
    .down   (down),
    .reinit (reinit),
    .enc    (enc),
    .cnt    (count_o),
    .dir    (count_down_o),
    .upd    (update_o)
  );

  // R11: the direction output is 0 outside the encoder modes
  a_r11_dir_up_outside_encoder: assert property (@(posedge clk) disable iff (rst)
    (slave_mode_i[2] || slave_mode_i == MD_OFF) |=> (!count_down_o || $past(enc)));

endmodule

// File: tb/tmr_slave_ctrl_tb.sv
`timescale 1ns/1ps
module tmr_slave_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cen;
  logic [2:0]  sel;
  logic [2:0]  mode;
  logic [3:0]  itr;
  logic        in1, in2, ext;
  logic [15:0] arr;
  logic [15:0] cnt;
  logic        dwn, upd;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  tmr_slave_ctrl u_dut (
    .clk          (clk),
    .rst          (rst),
    .cnt_en_i     (cen),
    .trig_sel_i   (sel),
    .slave_mode_i (mode),
    .int_trig_i   (itr),
    .in1_i        (in1),
    .in2_i        (in2),
    .ext_trig_i   (ext),
    .reload_i     (arr),
    .count_o      (cnt),
    .count_down_o (dwn),
    .update_o     (upd)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int c, input int d, input int u);
    chk({tag, " count"}, int'(cnt), c);
    chk({tag, " dir"}, int'(dwn), d);
    chk({tag, " update"}, int'(upd), u);
  endtask

  task automatic restart(input logic [2:0] m, input logic [2:0] s, input int r);
    rst  = 1'b1;
    cen  = 1'b0;
    itr  = 4'b0000;
    in1  = 1'b0;
    in2  = 1'b0;
    ext  = 1'b0;
    mode = m;
    sel  = s;
    arr  = 16'(r);
    tick(2);
    rst = 1'b0;
    tick(1);
  endtask

  // R1: reset values, and a trigger already high at release is not an edge
  task automatic t_reset();
    restart(3'b111, 3'b111, 100);
    rst = 1'b1;
    cen = 1'b1;
    ext = 1'b1;
    tick(2);
    chk_state("R1 in reset", 0, 0, 0);
    rst = 1'b0;
    tick(1);
    chk_state("R1 first cycle", 0, 0, 0);
    tick(3);
    chk("R1 no edge after release", int'(cnt), 0);
  endtask

  // R2 and R3: free run with wrap at the reload value
  task automatic t_free();
    restart(3'b000, 3'b000, 3);
    chk("R2 idle without enable", int'(cnt), 0);
    cen = 1'b1;
    tick(1);
    chk("R2 first step", int'(cnt), 1);
    tick(2);
    chk_state("R3 at reload", 3, 0, 0);
    tick(1);
    chk_state("R3 wrap up", 0, 0, 1);
    tick(1);
    chk_state("R3 pulse one cycle", 1, 0, 0);
    cen = 1'b0;
    tick(3);
    chk("R2 hold with enable low", int'(cnt), 1);
  endtask

  // R4: external-clock mode on the external trigger
  task automatic t_extclk();
    restart(3'b111, 3'b111, 100);
    cen = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ext = 1'b1; tick(2);
      ext = 1'b0; tick(2);
    end
    chk("R4 three edges", int'(cnt), 3);
    ext = 1'b1;
    tick(1);
    chk("R4 not yet", int'(cnt), 3);
    tick(1);
    chk("R4 second edge later", int'(cnt), 4);
    cen = 1'b0;
    ext = 1'b0; tick(2);
    ext = 1'b1; tick(2);
    chk("R4 enable low ignores edge", int'(cnt), 4);
  endtask

  // R5: gated by input 1 level
  task automatic t_gate();
    restart(3'b101, 3'b101, 100);
    cen = 1'b1;
    in1 = 1'b1;
    tick(5);
    in1 = 1'b0;
    tick(4);
    chk("R5 held after gate low", int'(cnt), 5);
    in1 = 1'b1;
    tick(3);
    chk("R5 resumes from held value", int'(cnt), 7);
  endtask

  // R6: gated mode with the transition detector is inert
  task automatic t_gate_detector();
    restart(3'b101, 3'b100, 100);
    cen = 1'b1;
    for (int i = 0; i < 8; i++) begin
      in1 = ~in1;
      tick(1);
    end
    tick(2);
    chk("R6 no count", int'(cnt), 0);
    mode = 3'b000;
    tick(1);
    chk("R6 counter still live", int'(cnt), 1);
  endtask

  // R7: trigger start on internal trigger 0, enable ignored
  task automatic t_trigger();
    restart(3'b110, 3'b000, 100);
    tick(4);
    chk("R7 waits for edge", int'(cnt), 0);
    itr[0] = 1'b1;
    tick(1);
    chk("R7 edge sampled only", int'(cnt), 0);
    tick(1);
    chk("R7 started", int'(cnt), 1);
    itr[0] = 1'b0;
    tick(3);
    chk("R7 keeps running", int'(cnt), 4);
  endtask

  // R8: reset mode on input 2
  task automatic t_resetmode();
    restart(3'b100, 3'b110, 100);
    cen = 1'b1;
    tick(10);
    chk("R8 running", int'(cnt), 10);
    in2 = 1'b1;
    tick(1);
    chk_state("R8 before clear", 11, 0, 0);
    tick(1);
    chk_state("R8 cleared", 0, 0, 1);
    tick(1);
    chk_state("R8 runs on", 1, 0, 0);
    in2 = 1'b0;
    cen = 1'b0;
    tick(3);
    chk("R8 held without enable", int'(cnt), 1);
    in2 = 1'b1;
    tick(2);
    chk_state("R8 clear without enable", 0, 0, 1);
  endtask

  // R9: encoder on input 2 edges
  task automatic t_enc_b();
    restart(3'b001, 3'b000, 9);
    cen = 1'b1;
    in2 = 1'b1; tick(2);
    chk_state("R9 rise ref low down", 9, 1, 1);
    in2 = 1'b0; tick(2);
    chk_state("R9 fall ref low up", 0, 0, 1);
    in1 = 1'b1; tick(3);
    chk("R9 input 1 edge ignored", int'(cnt), 0);
    in2 = 1'b1; tick(2);
    chk_state("R9 rise ref high up", 1, 0, 0);
    in2 = 1'b0; tick(2);
    chk_state("R9 fall ref high down", 0, 1, 0);
  endtask

  // R10: encoder on input 1 edges
  task automatic t_enc_a();
    restart(3'b010, 3'b000, 9);
    cen = 1'b1;
    in1 = 1'b1; tick(2);
    chk_state("R10 rise ref low up", 1, 0, 0);
    in2 = 1'b1; tick(3);
    chk("R10 input 2 edge ignored", int'(cnt), 1);
    in1 = 1'b0; tick(2);
    chk_state("R10 fall ref high up", 2, 0, 0);
    in1 = 1'b1; tick(2);
    chk_state("R10 rise ref high down", 1, 1, 0);
  endtask

  // R11: full quadrature on both inputs
  task automatic t_enc_ab();
    restart(3'b011, 3'b000, 9);
    cen = 1'b1;
    in1 = 1'b1; tick(2);
    in2 = 1'b1; tick(2);
    in1 = 1'b0; tick(2);
    in2 = 1'b0; tick(2);
    chk_state("R11 four forward steps", 4, 0, 0);
    in2 = 1'b1; tick(2);
    chk_state("R11 reverse step", 3, 1, 0);
    in1 = 1'b1;
    in2 = 1'b0;
    tick(3);
    chk("R11 double edge dropped", int'(cnt), 3);
    in2 = 1'b1; tick(2);
    chk_state("R11 live after double edge", 4, 0, 0);
    mode = 3'b000;
    cen  = 1'b0;
    tick(1);
    chk("R11 dir cleared outside encoder", int'(dwn), 0);
  endtask

  // R12 and R13: selection changes and source mapping
  task automatic t_select();
    restart(3'b111, 3'b000, 100);
    cen = 1'b1;
    itr = 4'b0010;
    tick(2);
    chk("R13 int 0 low gives no edge", int'(cnt), 0);
    sel = 3'b001;
    tick(3);
    chk("R12 no edge on selection change", int'(cnt), 0);
    itr[1] = 1'b0; tick(2);
    itr[1] = 1'b1; tick(2);
    chk("R13 code 001 picks int 1", int'(cnt), 1);
    sel = 3'b011;
    tick(2);
    itr[2] = 1'b1; tick(2);
    itr[2] = 1'b0; tick(2);
    chk("R13 int 2 ignored on code 011", int'(cnt), 1);
    itr[3] = 1'b1; tick(2);
    itr[3] = 1'b0; tick(2);
    chk("R13 code 011 picks int 3", int'(cnt), 2);
    sel = 3'b100;
    tick(2);
    in1 = 1'b1; tick(3);
    in1 = 1'b0; tick(3);
    chk("R13 code 100 pulses on both edges", int'(cnt), 4);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_free();
    t_extclk();
    t_gate();
    t_gate_detector();
    t_trigger();
    t_resetmode();
    t_enc_b();
    t_enc_a();
    t_enc_ab();
    t_select();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule